// File: doc/BRIEF.md
# In-Order Load Return Sequencer

This block sits between the load issue stage and the integer register write port of a core with a first-level data cache. Each cycle the issue stage may present one load. The load carries a tag, a signed flag, a size code and the three low address bits, and the cache lookup result (hit or miss) arrives in the same cycle. An aligned load goes into a small ordered queue. A misaligned load is rejected and raises a trap pulse that carries its tag. Results leave through a single writeback strobe with the load's tag, strictly in the order the loads were accepted.

A hit normally completes two cycles after issue. A signed load narrower than 64 bits needs an extra cycle for sign extension. While such a load is in flight, every load accepted in the cycles that follow it without a gap is also put on the three-cycle timing. A miss waits for a fill-completion pulse from the outer cache. Because returns stay in order, a pending miss holds back every younger load, including ones that hit. When the queue holds its maximum number of loads, a stall output tells the issue stage to stop.

Top module: `load_return_seq`

## Requirements
- R1: During and right after reset the writeback strobe, the trap pulse and the stall output are all low, and no load is outstanding.
- R2: An accepted, aligned hit that is not signed-narrow and is not issued in delayed mode, with nothing older pending, produces its writeback strobe with its tag in cycle c+2, where c is its issue cycle. This includes a signed 64-bit load (size code 3).
- R3: An accepted, aligned hit with the signed flag set and a size code of 0 (byte), 1 (half) or 2 (word) produces its writeback in cycle c+3, not before.
- R4: Delayed mode starts when a signed-narrow load is accepted. It stays on while a load is accepted in every following cycle, and it ends after the first cycle with no accepted load. Any hit accepted in delayed mode returns in cycle c+3. A hit accepted after the gap returns in c+2 again.
- R5: Writebacks carry tags in exactly the order their loads were accepted. A load whose data is not yet available (an unfilled miss) blocks every younger load, even one whose own latency has already elapsed.
- R6: A fill pulse in cycle f completes the oldest outstanding miss that has not yet been filled. If that load is the oldest outstanding load, its writeback appears in cycle f+1.
- R7: The writeback strobe is asserted in at most one cycle per accepted load, never while the queue is empty, and each accepted load eventually returns exactly once.
- R8: A load is misaligned if its size is half (1) and addr[0] is set, word (2) and addr[1:0] is nonzero, or doubleword (3) and addr[2:0] is nonzero. A misaligned load is never queued and never written back. The trap pulse goes high in cycle c+1 with trap tag equal to the load's tag.
- R9: The stall output is high exactly while DEPTH loads are outstanding. A load presented while stall is high is not accepted and never produces a writeback.
- R10: A fill pulse that arrives while no unfilled miss is outstanding is ignored. It gives no credit to a miss issued later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_valid_i | input | 1 | A load is presented this cycle |
| issue_tag_i | input | TAG_W | Tag of the presented load |
| issue_signed_i | input | 1 | Load sign-extends its result |
| issue_size_i | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 doubleword |
| issue_addr_i | input | 3 | Low address bits, used for the alignment check |
| issue_miss_i | input | 1 | Cache lookup for the presented load missed |
| fill_valid_i | input | 1 | Outer cache completed one miss fill |
| stall_o | output | 1 | Queue full; issue stage must hold |
| trap_o | output | 1 | Misaligned load rejected in the previous cycle |
| trap_tag_o | output | TAG_W | Tag of the rejected load |
| wb_valid_o | output | 1 | Register writeback strobe |
| wb_tag_o | output | TAG_W | Tag of the load being written back |

## Verification
The return timing is first tried with single loads into an empty queue: an unsigned word, a signed doubleword and a signed byte. These separate the two-cycle path from the three-cycle path. A consecutive chain that starts with a signed half, followed by a load issued after a one-cycle gap, shows whether delayed mode is entered and left at the right cycle. A miss with younger hits queued behind it, a stray fill with nothing pending, misaligned halves, words and doublewords, and a push to a full queue each target ordering, fill credit, rejection and back-pressure separately. A long seeded random mix of sizes, signs, misses, fills and occasional misaligned addresses is then compared cycle by cycle against a reference queue in the bench. That comparison catches ordering slips that only show up when misses, fills and delayed-mode chains overlap.

// File: rtl/lrs_pkg.sv
`timescale 1ns/1ps
package lrs_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_DBL  = 2'd3;

  function automatic logic addr_misaligned(input logic [1:0] size, input logic [2:0] addr);
    case (size)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return addr[0];
      SZ_WORD: return |addr[1:0];
      default: return |addr;
    endcase
  endfunction

  function automatic logic signed_narrow(input logic sgn, input logic [1:0] size);
    return sgn && (size != SZ_DBL);
  endfunction

endpackage

// File: rtl/lrs_issue_check.sv
`timescale 1ns/1ps
module lrs_issue_check #(
  parameter int TAG_W    = 4,
  parameter int LAT_W    = 2,
  parameter int FAST_LAT = 2,
  parameter int SLOW_LAT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             signed_i,
  input  logic [1:0]       size_i,
  input  logic [2:0]       addr_i,
  input  logic             full_i,
  output logic             push_o,
  output logic [LAT_W-1:0] cnt_o,
  output logic             slow_mode_o,
  output logic             trap_o,
  output logic [TAG_W-1:0] trap_tag_o
);
  import lrs_pkg::*;

  logic misal, narrow, use_slow;
  logic slow_q, trap_q;
  logic [TAG_W-1:0] trap_tag_q;

  assign misal    = addr_misaligned(size_i, addr_i);
  assign narrow   = signed_narrow(signed_i, size_i);
  assign push_o   = valid_i && !misal && !full_i;
  assign use_slow = narrow || slow_q;
  // counter is loaded with latency-1: one cycle is spent entering the queue
  assign cnt_o    = use_slow ? LAT_W'(SLOW_LAT - 1) : LAT_W'(FAST_LAT - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_q     <= 1'b0;
      trap_q     <= 1'b0;
      trap_tag_q <= '0;
    end else begin
      slow_q <= push_o ? use_slow : 1'b0;
      trap_q <= valid_i && misal;
      if (valid_i && misal) trap_tag_q <= tag_i;
    end
  end

  assign slow_mode_o = slow_q;
  assign trap_o      = trap_q;
  assign trap_tag_o  = trap_tag_q;

endmodule

// File: rtl/lrs_queue.sv
`timescale 1ns/1ps
module lrs_queue #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 4,
  parameter int LAT_W = 2,
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [TAG_W-1:0] push_tag_i,
  input  logic             push_miss_i,
  input  logic [LAT_W-1:0] push_cnt_i,
  input  logic             fill_i,
  output logic             wb_valid_o,
  output logic [TAG_W-1:0] wb_tag_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);

  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic [DEPTH-1:0] wait_v;
  logic [DEPTH-1:0] fill_sel;
  logic [DEPTH-1:0][TAG_W-1:0] tag_v;
  logic [DEPTH-1:0][LAT_W-1:0] cnt_v;
  logic pop;

  function automatic logic [PTR_W-1:0] ptr_nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // oldest unfilled miss, walking from head
  always_comb begin
    logic found;
    logic [PTR_W-1:0] p;
    fill_sel = '0;
    found    = 1'b0;
    p        = head_q;
    for (int k = 0; k < DEPTH; k++) begin
      if (fill_i && !found && (CNT_W'(k) < count_q) && wait_v[p]) begin
        fill_sel[p] = 1'b1;
        found       = 1'b1;
      end
      p = ptr_nxt(p);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [TAG_W-1:0] tag_r;
    logic             wait_r;
    logic [LAT_W-1:0] cnt_r;
    logic             load_here;

    assign load_here = push_i && (tail_q == PTR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_r  <= '0;
        wait_r <= 1'b0;
        cnt_r  <= '0;
      end else if (load_here) begin
        tag_r  <= push_tag_i;
        wait_r <= push_miss_i;
        cnt_r  <= push_miss_i ? '0 : push_cnt_i;
      end else begin
        if (fill_sel[g]) wait_r <= 1'b0;
        if (cnt_r != '0) cnt_r <= cnt_r - 1'b1;
      end
    end

    assign tag_v[g]  = tag_r;
    assign wait_v[g] = wait_r;
    assign cnt_v[g]  = cnt_r;
  end

  assign wb_valid_o = (count_q != '0) && !wait_v[head_q] && (cnt_v[head_q] == '0);
  assign wb_tag_o   = tag_v[head_q];
  assign pop        = wb_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (pop)    head_q <= ptr_nxt(head_q);
      if (push_i) tail_q <= ptr_nxt(tail_q);
      case ({push_i, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign count_o = count_q;
  assign full_o  = (count_q == CNT_W'(DEPTH));

endmodule

// File: rtl/load_return_seq.sv
`timescale 1ns/1ps
module load_return_seq #(
  parameter int DEPTH    = 4,
  parameter int TAG_W    = 4,
  parameter int FAST_LAT = 2,
  parameter int SLOW_LAT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_valid_i,
  input  logic [TAG_W-1:0] issue_tag_i,
  input  logic             issue_signed_i,
  input  logic [1:0]       issue_size_i,
  input  logic [2:0]       issue_addr_i,
  input  logic             issue_miss_i,
  input  logic             fill_valid_i,
  output logic             stall_o,
  output logic             trap_o,
  output logic [TAG_W-1:0] trap_tag_o,
  output logic             wb_valid_o,
  output logic [TAG_W-1:0] wb_tag_o
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int LAT_W = (SLOW_LAT > 2) ? $clog2(SLOW_LAT) : 1;

  logic             push;
  logic [LAT_W-1:0] push_cnt;
  logic             slow_mode;
  logic [CNT_W-1:0] q_count;
  logic             full;

  lrs_issue_check #(
    .TAG_W(TAG_W), .LAT_W(LAT_W), .FAST_LAT(FAST_LAT), .SLOW_LAT(SLOW_LAT)
  ) u_issue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (issue_valid_i),
    .tag_i      (issue_tag_i),
    .signed_i   (issue_signed_i),
    .size_i     (issue_size_i),
    .addr_i     (issue_addr_i),
    .full_i     (full),
    .push_o     (push),
    .cnt_o      (push_cnt),
    .slow_mode_o(slow_mode),
    .trap_o     (trap_o),
    .trap_tag_o (trap_tag_o)
  );

  lrs_queue #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .LAT_W(LAT_W)
  ) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_tag_i (issue_tag_i),
    .push_miss_i(issue_miss_i),
    .push_cnt_i (push_cnt),
    .fill_i     (fill_valid_i),
    .wb_valid_o (wb_valid_o),
    .wb_tag_o   (wb_tag_o),
    .count_o    (q_count),
    .full_o     (full)
  );

  assign stall_o = full;

endmodule

// File: rtl/load_return_seq_chk.sv
`timescale 1ns/1ps
module load_return_seq_chk #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 4,
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_valid_i,
  input logic [TAG_W-1:0] issue_tag_i,
  input logic             issue_signed_i,
  input logic [1:0]       issue_size_i,
  input logic [2:0]       issue_addr_i,
  input logic             issue_miss_i,
  input logic             stall_o,
  input logic             trap_o,
  input logic [TAG_W-1:0] trap_tag_o,
  input logic             wb_valid_o,
  input logic [TAG_W-1:0] wb_tag_o,
  input logic [CNT_W-1:0] q_count,
  input logic             slow_mode
);
  import lrs_pkg::*;

  logic misal, narrow, hit_ok;
  assign misal  = addr_misaligned(issue_size_i, issue_addr_i);
  assign narrow = signed_narrow(issue_signed_i, issue_size_i);
  assign hit_ok = issue_valid_i && !misal && !stall_o && !issue_miss_i && (q_count == '0);

  assert_fast_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_ok && !narrow && !slow_mode) |-> ##2 (wb_valid_o && wb_tag_o == $past(issue_tag_i, 2)));

  assert_slow_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_ok && narrow) |-> ##2 !wb_valid_o);

  assert_slow_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_ok && narrow) |-> ##3 (wb_valid_o && wb_tag_o == $past(issue_tag_i, 3)));

  assert_empty_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_count == '0) |-> !wb_valid_o);

  assert_trap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && misal) |=> (trap_o && trap_tag_o == $past(issue_tag_i)));

  assert_trap_no_push_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && misal && !wb_valid_o) |=> (q_count == $past(q_count)));

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count <= CNT_W'(DEPTH));

  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !wb_valid_o) |=> stall_o);

endmodule

bind load_return_seq load_return_seq_chk #(
  .DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_valid_i (issue_valid_i),
  .issue_tag_i   (issue_tag_i),
  .issue_signed_i(issue_signed_i),
  .issue_size_i  (issue_size_i),
  .issue_addr_i  (issue_addr_i),
  .issue_miss_i  (issue_miss_i),
  .stall_o       (stall_o),
  .trap_o        (trap_o),
  .trap_tag_o    (trap_tag_o),
  .wb_valid_o    (wb_valid_o),
  .wb_tag_o      (wb_tag_o),
  .q_count       (q_count),
  .slow_mode     (slow_mode)
);

// File: tb/load_return_seq_tb.sv
`timescale 1ns/1ps
module load_return_seq_tb;
  localparam int DEPTH = 4;
  localparam int TAG_W = 4;
  localparam int NTAG  = 1 << TAG_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic issue_valid_i = 1'b0, issue_signed_i = 1'b0, issue_miss_i = 1'b0, fill_valid_i = 1'b0;
  logic [TAG_W-1:0] issue_tag_i = '0;
  logic [1:0] issue_size_i = '0;
  logic [2:0] issue_addr_i = '0;
  logic stall_o, trap_o, wb_valid_o;
  logic [TAG_W-1:0] trap_tag_o, wb_tag_o;

  always #2.5 clk = ~clk;

  load_return_seq #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .issue_valid_i(issue_valid_i), .issue_tag_i(issue_tag_i),
    .issue_signed_i(issue_signed_i), .issue_size_i(issue_size_i),
    .issue_addr_i(issue_addr_i), .issue_miss_i(issue_miss_i),
    .fill_valid_i(fill_valid_i), .stall_o(stall_o), .trap_o(trap_o),
    .trap_tag_o(trap_tag_o), .wb_valid_o(wb_valid_o), .wb_tag_o(wb_tag_o)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  int cyc = 0;

  // reference queue: ready cycle, -1 while waiting for a fill
  int m_tag [0:DEPTH];
  int m_rdy [0:DEPTH];
  int m_n = 0;
  bit m_slow = 1'b0;
  bit e_trap = 1'b0;
  int e_trap_tag = 0;
  int wb_cyc [0:NTAG-1];
  int is_cyc [0:NTAG-1];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  function automatic bit ref_misal(input int sz, input int a);
    if (sz == 1) return (a % 2) != 0;
    if (sz == 2) return (a % 4) != 0;
    if (sz == 3) return a != 0;
    return 1'b0;
  endfunction

  function automatic int ref_lat(input bit sgn, input int sz, input bit slow);
    return (slow || (sgn && sz != 3)) ? 3 : 2;
  endfunction

  task automatic clear_marks();
    for (int i = 0; i < NTAG; i++) begin wb_cyc[i] = -1; is_cyc[i] = -1; end
  endtask

  task automatic step(input bit v, input int tag, input bit sgn, input int sz,
                      input int addr, input bit miss, input bit fill);
    bit e_wb, e_stall, mis, acc, sn;
    @(negedge clk);
    e_stall = (m_n == DEPTH);
    e_wb    = (m_n > 0) && (m_rdy[0] >= 0) && (m_rdy[0] <= cyc);
    chk(wb_valid_o == e_wb, "R7", wb_valid_o, e_wb);
    if (e_wb) chk(int'(wb_tag_o) == m_tag[0], "R5", wb_tag_o, m_tag[0]);
    chk(stall_o == e_stall, "R9", stall_o, e_stall);
    chk(trap_o == e_trap, "R8", trap_o, e_trap);
    if (e_trap) chk(int'(trap_tag_o) == e_trap_tag, "R8", trap_tag_o, e_trap_tag);
    if (wb_valid_o) wb_cyc[wb_tag_o] = cyc;

    issue_valid_i  = v;
    issue_tag_i    = TAG_W'(tag);
    issue_signed_i = sgn;
    issue_size_i   = 2'(sz);
    issue_addr_i   = 3'(addr);
    issue_miss_i   = miss;
    fill_valid_i   = fill;

    if (e_wb) begin
      for (int i = 0; i < DEPTH; i++) begin m_tag[i] = m_tag[i+1]; m_rdy[i] = m_rdy[i+1]; end
      m_n--;
    end
    if (fill) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i < m_n && m_rdy[i] < 0) begin m_rdy[i] = cyc + 1; break; end
      end
    end
    mis = ref_misal(sz, addr);
    e_trap = v && mis;
    e_trap_tag = tag;
    acc = v && !mis && !e_stall;
    sn  = sgn && sz != 3;
    if (acc) begin
      m_tag[m_n] = tag;
      m_rdy[m_n] = miss ? -1 : cyc + ref_lat(sgn, sz, m_slow);
      m_n++;
      is_cyc[tag] = cyc;
    end
    m_slow = acc ? (m_slow || sn) : 1'b0;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic hit(input int tag, input bit sgn, input int sz);
    step(1, tag, sgn, sz, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R7 watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int fill_cyc;
    clear_marks();
    repeat (3) @(negedge clk);
    chk(!wb_valid_o && !stall_o && !trap_o, "R1", {wb_valid_o, stall_o, trap_o}, 0);
    rst_ni = 1'b1;
    idle(2);
    chk(!wb_valid_o && !stall_o && !trap_o, "R1", {wb_valid_o, stall_o, trap_o}, 0);

    // R2: unsigned word and signed doubleword, two-cycle return
    hit(1, 0, 2); idle(4);
    chk(wb_cyc[1] == is_cyc[1] + 2, "R2", wb_cyc[1], is_cyc[1] + 2);
    hit(2, 1, 3); idle(4);
    chk(wb_cyc[2] == is_cyc[2] + 2, "R2", wb_cyc[2], is_cyc[2] + 2);

    // R3: signed byte, three-cycle return
    hit(3, 1, 0); idle(5);
    chk(wb_cyc[3] == is_cyc[3] + 3, "R3", wb_cyc[3], is_cyc[3] + 3);

    // R4: consecutive chain after signed half, then a gap
    hit(4, 1, 1); hit(5, 0, 2); hit(6, 0, 3); idle(1); hit(7, 0, 2); idle(6);
    chk(wb_cyc[5] == is_cyc[5] + 3, "R4", wb_cyc[5], is_cyc[5] + 3);
    chk(wb_cyc[6] == is_cyc[6] + 3, "R4", wb_cyc[6], is_cyc[6] + 3);
    chk(wb_cyc[7] == is_cyc[7] + 2, "R4", wb_cyc[7], is_cyc[7] + 2);

    // R5/R6: miss blocks younger hits until fill
    clear_marks();
    step(1, 8, 0, 2, 0, 1, 0); hit(9, 0, 2); hit(10, 0, 0); idle(6);
    chk(wb_cyc[9] == -1 && wb_cyc[10] == -1, "R5", wb_cyc[9], -1);
    fill_cyc = cyc;
    step(0, 0, 0, 0, 0, 0, 1); idle(5);
    chk(wb_cyc[8] == fill_cyc + 1, "R6", wb_cyc[8], fill_cyc + 1);
    chk(wb_cyc[9] == fill_cyc + 2, "R5", wb_cyc[9], fill_cyc + 2);
    chk(wb_cyc[10] == fill_cyc + 3, "R5", wb_cyc[10], fill_cyc + 3);

    // R10: stray fill with nothing pending
    step(0, 0, 0, 0, 0, 0, 1); step(0, 0, 0, 0, 0, 0, 1);
    step(1, 11, 0, 3, 0, 1, 0); idle(5);
    chk(wb_cyc[11] == -1, "R10", wb_cyc[11], -1);
    fill_cyc = cyc;
    step(0, 0, 0, 0, 0, 0, 1); idle(3);
    chk(wb_cyc[11] == fill_cyc + 1, "R6", wb_cyc[11], fill_cyc + 1);

    // R8: misaligned half, word, doubleword rejected; aligned doubleword accepted
    clear_marks();
    step(1, 12, 0, 1, 1, 0, 0); step(1, 13, 1, 2, 2, 0, 0);
    step(1, 14, 0, 3, 4, 0, 0); step(1, 15, 0, 3, 0, 0, 0); idle(5);
    chk(wb_cyc[12] == -1, "R8", wb_cyc[12], -1);
    chk(wb_cyc[13] == -1, "R8", wb_cyc[13], -1);
    chk(wb_cyc[14] == -1, "R8", wb_cyc[14], -1);
    chk(wb_cyc[15] == is_cyc[15] + 2, "R8", wb_cyc[15], is_cyc[15] + 2);

    // R9: fill the queue with misses, push while stalled
    clear_marks();
    for (int t = 0; t < DEPTH; t++) step(1, t, 0, 2, 0, 1, 0);
    step(1, 9, 0, 2, 0, 0, 0);
    chk(stall_o == 1'b1, "R9", stall_o, 1);
    for (int t = 0; t < DEPTH; t++) step(0, 0, 0, 0, 0, 0, 1);
    idle(4);
    chk(wb_cyc[9] == -1, "R9", wb_cyc[9], -1);
    chk(wb_cyc[DEPTH-1] >= 0, "R7", wb_cyc[DEPTH-1], 0);

    // random mix against the reference queue
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      int sz, a;
      sz = int'($urandom % 4);
      a  = int'($urandom % 8);
      if (($urandom % 8) != 0) a = (sz == 3) ? 0 : (sz == 2) ? (a & 4) : (sz == 1) ? (a & 6) : a;
      step(($urandom % 3) != 0, i % NTAG, $urandom % 2, sz, a, ($urandom % 5) == 0, ($urandom % 4) == 0);
    end
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 0, 0, 1);
    chk(m_n == 0 && !wb_valid_o, "R7", m_n, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule